// File: doc/BRIEF.md
# Move Slot Decoder for a Transport-Triggered Datapath

The block takes one wide instruction word for a datapath where the program lists only data transports. Each of nine move slots names one transport on its own 32-bit bus. The slot holds a guard code, a source socket address and a destination socket address. There is no opcode: a unit starts work as a side effect of a write to its trigger socket. In one cycle the decoder splits every slot into its fields and evaluates each guard against two boolean guard flags. For each bus it then produces a one-hot source-socket select, a long-immediate select and a one-hot destination-socket write enable.

A slot whose guard is false, or whose source address maps to nothing, is squashed. It drives nothing and writes nothing, so an unused slot is simply a slot coded with the "never" guard. The word also carries a 32-bit constant field, and any slot can put that constant on its bus by naming the all-ones source address. When two live slots of one word name the same destination socket, the decoder raises a clash flag.

All outputs are registered, one cycle after the word is presented with its valid strobe.

Top module: `mvdec_top`

## Requirements
- R1: The 180-bit word is packed from bit 0 upward in slot order (slot 0 first). Slots 0, 1, 2 and 6 are 17 bits wide and the other slots are 16 bits wide, so slots start at bits 0, 17, 34, 51, 67, 83, 99, 116 and 132. Inside a slot the destination address takes the low bits (6 bits in the wide slots, 5 in the narrow ones), the 9-bit source address sits above it, and the 2-bit guard code is on top. The constant field is bits 179:148.
- R2: Guard code 0 is always true and code 1 is never true. Code 2 follows `guardFlags[0]` and code 3 follows `guardFlags[1]`. A slot with a false guard has `busLive`, `busImmSel`, its source select slice and its destination enable slice all zero.
- R3: A live slot with source address below `SRC_SOCKETS` sets exactly bit `slot*SRC_SOCKETS+address` of `busSrcSel`. Source address 511 sets `busImmSel[slot]` and no source select bit. Any other source address squashes the slot.
- R4: A live slot sets exactly bit `slot*64+address` of `busDstWe` for its destination address. A squashed slot sets none.
- R5: Outputs change only at a rising clock edge and reflect the word sampled at that edge. A word sampled with `instrValid` low leaves every output zero after the edge.
- R6: After an edge that samples `instrValid` high, `immValue` holds word bits 179:148, whether or not any slot uses it.
- R7: `dstClash` is 1 exactly when two or more live slots of the same word name the same destination address. Each such slot still raises its own enable bit. Squashed slots never count toward a clash.
- R8: While `rstN` is low, every output is zero regardless of the inputs.
- R9: All nine slots are decoded independently in the same cycle, so a word can make all nine buses live at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| instrValid | input | 1 | The word on `instrWord` is to be decoded at this edge |
| instrWord | input | 180 | Instruction word: nine move slots and the constant field |
| guardFlags | input | 2 | Boolean guard flags that guard codes 2 and 3 test |
| busSrcSel | output | 9*SRC_SOCKETS | Per bus, one-hot select of the output socket driving it |
| busImmSel | output | 9 | Per bus, the constant field drives the bus |
| busDstWe | output | 9*64 | Per bus, one-hot write enable of the input socket capturing it |
| busLive | output | 9 | Per bus, the transport executes this cycle |
| immValue | output | 32 | Registered constant field |
| dstClash | output | 1 | Two live transports target one destination socket |

## Verification
A table of single-slot words is applied with the other slots coded as never-guarded. The table walks all four guard codes with both flag values, mapped and unmapped source addresses, the constant source, and the extreme destination addresses of wide and narrow slots. This shows whether each slot's fields are cut from the right bit positions and whether squashing keeps the bus fully quiet. A word with all nine slots live, each on a distinct socket, is checked against one where two slots collide and one where the colliding partner is guarded off. This separates real clashes from ones raised by squashed transports. Further directed words check bubbles, the one-cycle latency, the constant field with no slot using it, and the slot 8 to constant field boundary.

// File: rtl/mvdec_pkg.sv
package mvdec_pkg;

  localparam int SLOT_COUNT = 9;
  localparam int GUARD_W    = 2;
  localparam int SRC_W      = 9;
  localparam int DST_MAX_W  = 6;
  localparam int IMM_W      = 32;
  localparam int MAX_SLOT_W = GUARD_W + SRC_W + DST_MAX_W;

  localparam logic [SRC_W-1:0] IMM_SRC_ADDR = '1;

  typedef enum logic [GUARD_W-1:0] {
    GRD_ALWAYS = 2'd0,
    GRD_NEVER  = 2'd1,
    GRD_FLAG0  = 2'd2,
    GRD_FLAG1  = 2'd3
  } guardCode_e;

  // wide destination field in slots 0..2 and 6, narrow elsewhere
  function automatic int dstWidth(input int s);
    return (s < 3 || s == 6) ? DST_MAX_W : DST_MAX_W - 1;
  endfunction

  function automatic int slotWidth(input int s);
    return GUARD_W + SRC_W + dstWidth(s);
  endfunction

  function automatic int slotBase(input int s);
    int acc;
    acc = 0;
    for (int k = 0; k < s; k++) acc += slotWidth(k);
    return acc;
  endfunction

  localparam int SLOT_BITS = slotBase(SLOT_COUNT);
  localparam int WORD_W    = SLOT_BITS + IMM_W;
  localparam int DST_SOCKETS = 2 ** DST_MAX_W;

  typedef struct packed {
    guardCode_e             guard;
    logic [SRC_W-1:0]       src;
    logic [DST_MAX_W-1:0]   dst;
  } slotFields_t;

  typedef struct packed {
    logic live;
    logic fromImm;
  } slotStrobe_t;

  typedef struct packed {
    logic                          captureImm;
    slotStrobe_t [SLOT_COUNT-1:0]  slot;
  } ctrlStrobe_t;

endpackage

// File: rtl/mvdec_ctrl.sv
module mvdec_ctrl
  import mvdec_pkg::*;
#(
  parameter int SRC_SOCKETS = 32
) (
  input  logic                         instrValid,
  input  logic [1:0]                   guardFlags,
  input  slotFields_t [SLOT_COUNT-1:0] fields,
  output ctrlStrobe_t                  strobe
);

  always_comb begin
    strobe.captureImm = instrValid;
    for (int s = 0; s < SLOT_COUNT; s++) begin
      logic guardOk;
      logic srcIsImm;
      logic srcMapped;
      unique case (fields[s].guard)
        GRD_ALWAYS: guardOk = 1'b1;
        GRD_NEVER:  guardOk = 1'b0;
        GRD_FLAG0:  guardOk = guardFlags[0];
        GRD_FLAG1:  guardOk = guardFlags[1];
      endcase
      srcIsImm  = (fields[s].src == IMM_SRC_ADDR);
      srcMapped = (int'(fields[s].src) < SRC_SOCKETS);
      strobe.slot[s].live    = instrValid && guardOk && (srcIsImm || srcMapped);
      strobe.slot[s].fromImm = instrValid && guardOk && srcIsImm;
    end
  end

endmodule

// File: rtl/mvdec_datapath.sv
module mvdec_datapath
  import mvdec_pkg::*;
#(
  parameter int SRC_SOCKETS = 32
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  logic [WORD_W-1:0]                   instrWord,
  input  ctrlStrobe_t                         strobe,
  output slotFields_t [SLOT_COUNT-1:0]        fields,
  output logic [SLOT_COUNT*SRC_SOCKETS-1:0]   busSrcSel,
  output logic [SLOT_COUNT-1:0]               busImmSel,
  output logic [SLOT_COUNT*DST_SOCKETS-1:0]   busDstWe,
  output logic [SLOT_COUNT-1:0]               busLive,
  output logic [IMM_W-1:0]                    immValue,
  output logic                                dstClash
);

  logic [SLOT_COUNT*SRC_SOCKETS-1:0] srcNext;
  logic [SLOT_COUNT*DST_SOCKETS-1:0] dstNext;
  logic [SLOT_COUNT-1:0]             immNext;
  logic [SLOT_COUNT-1:0]             liveNext;
  logic [IMM_W-1:0]                  immValNext;
  logic                              clashNext;

  // field extraction: destination low, source above, guard on top
  always_comb begin
    for (int s = 0; s < SLOT_COUNT; s++) begin
      logic [MAX_SLOT_W-1:0] chunk;
      chunk = instrWord[slotBase(s) +: MAX_SLOT_W];
      if (dstWidth(s) == DST_MAX_W) begin
        fields[s].dst   = chunk[DST_MAX_W-1:0];
        fields[s].src   = chunk[DST_MAX_W +: SRC_W];
        fields[s].guard = guardCode_e'(chunk[DST_MAX_W+SRC_W +: GUARD_W]);
      end else begin
        fields[s].dst   = {1'b0, chunk[DST_MAX_W-2:0]};
        fields[s].src   = chunk[DST_MAX_W-1 +: SRC_W];
        fields[s].guard = guardCode_e'(chunk[DST_MAX_W-1+SRC_W +: GUARD_W]);
      end
    end
  end

  // one-hot socket enables per bus
  always_comb begin
    srcNext  = '0;
    dstNext  = '0;
    immNext  = '0;
    liveNext = '0;
    for (int s = 0; s < SLOT_COUNT; s++) begin
      liveNext[s] = strobe.slot[s].live;
      immNext[s]  = strobe.slot[s].fromImm;
      if (strobe.slot[s].live && !strobe.slot[s].fromImm)
        srcNext[s*SRC_SOCKETS + int'(fields[s].src)] = 1'b1;
      if (strobe.slot[s].live)
        dstNext[s*DST_SOCKETS + int'(fields[s].dst)] = 1'b1;
    end
  end

  // destination collision scan over every socket
  always_comb begin
    clashNext = 1'b0;
    for (int j = 0; j < DST_SOCKETS; j++) begin
      logic seen;
      seen = 1'b0;
      for (int s = 0; s < SLOT_COUNT; s++) begin
        if (dstNext[s*DST_SOCKETS + j]) begin
          if (seen) clashNext = 1'b1;
          seen = 1'b1;
        end
      end
    end
  end

  assign immValNext = strobe.captureImm ? instrWord[WORD_W-1 -: IMM_W] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busSrcSel <= '0;
      busImmSel <= '0;
      busDstWe  <= '0;
      busLive   <= '0;
      immValue  <= '0;
      dstClash  <= 1'b0;
    end else begin
      busSrcSel <= srcNext;
      busImmSel <= immNext;
      busDstWe  <= dstNext;
      busLive   <= liveNext;
      immValue  <= immValNext;
      dstClash  <= clashNext;
    end
  end

endmodule

// File: rtl/mvdec_top.sv
module mvdec_top
  import mvdec_pkg::*;
#(
  parameter int SRC_SOCKETS = 32
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               instrValid,
  input  logic [WORD_W-1:0]                  instrWord,
  input  logic [1:0]                         guardFlags,
  output logic [SLOT_COUNT*SRC_SOCKETS-1:0]  busSrcSel,
  output logic [SLOT_COUNT-1:0]              busImmSel,
  output logic [SLOT_COUNT*DST_SOCKETS-1:0]  busDstWe,
  output logic [SLOT_COUNT-1:0]              busLive,
  output logic [IMM_W-1:0]                   immValue,
  output logic                               dstClash
);

  slotFields_t [SLOT_COUNT-1:0] fields;
  ctrlStrobe_t                  strobe;

  mvdec_ctrl #(.SRC_SOCKETS(SRC_SOCKETS)) u_ctrl (
    .instrValid (instrValid),
    .guardFlags (guardFlags),
    .fields     (fields),
    .strobe     (strobe)
  );

  mvdec_datapath #(.SRC_SOCKETS(SRC_SOCKETS)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .instrWord (instrWord),
    .strobe    (strobe),
    .fields    (fields),
    .busSrcSel (busSrcSel),
    .busImmSel (busImmSel),
    .busDstWe  (busDstWe),
    .busLive   (busLive),
    .immValue  (immValue),
    .dstClash  (dstClash)
  );

endmodule

// File: rtl/mvdec_checker.sv
module mvdec_checker
  import mvdec_pkg::*;
#(
  parameter int SRC_SOCKETS = 32
) (
  input logic                               clk,
  input logic                               rstN,
  input logic                               instrValid,
  input logic [WORD_W-1:0]                  instrWord,
  input logic [SLOT_COUNT*SRC_SOCKETS-1:0]  busSrcSel,
  input logic [SLOT_COUNT-1:0]              busImmSel,
  input logic [SLOT_COUNT*DST_SOCKETS-1:0]  busDstWe,
  input logic [SLOT_COUNT-1:0]              busLive,
  input logic [IMM_W-1:0]                   immValue,
  input logic                               dstClash
);

  for (genvar s = 0; s < SLOT_COUNT; s++) begin : g_slot
    AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0({busImmSel[s], busSrcSel[s*SRC_SOCKETS +: SRC_SOCKETS]})); // R3
    AST_LIVE_HAS_DRIVER: assert property (@(posedge clk) disable iff (!rstN)
      busLive[s] |-> (|{busImmSel[s], busSrcSel[s*SRC_SOCKETS +: SRC_SOCKETS]})); // R3
    AST_DST_MATCHES_LIVE: assert property (@(posedge clk) disable iff (!rstN)
      $countones(busDstWe[s*DST_SOCKETS +: DST_SOCKETS]) == (busLive[s] ? 1 : 0)); // R4
  end

  AST_BUBBLE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(instrValid) |-> (busLive == '0 && immValue == '0 && !dstClash)); // R5
  AST_IMM_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    ($past(instrValid) && $past(rstN)) |-> immValue == $past(instrWord[WORD_W-1 -: IMM_W])); // R6
  AST_CLASH_NEEDS_TWO: assert property (@(posedge clk) disable iff (!rstN)
    dstClash |-> $countones(busLive) >= 2); // R7

endmodule

bind mvdec_top mvdec_checker #(.SRC_SOCKETS(SRC_SOCKETS)) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .instrValid (instrValid),
  .instrWord  (instrWord),
  .busSrcSel  (busSrcSel),
  .busImmSel  (busImmSel),
  .busDstWe   (busDstWe),
  .busLive    (busLive),
  .immValue   (immValue),
  .dstClash   (dstClash)
);

// File: tb/tb_mvdec_top.sv
module tb_mvdec_top;

  localparam int NS    = 9;
  localparam int SRC_N = 32;
  localparam int DST_N = 64;
  localparam int WW    = 180;
  localparam int NVEC  = 14;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            instrValid = 1'b0;
  logic [WW-1:0]   instrWord = '0;
  logic [1:0]      guardFlags = '0;
  logic [NS*SRC_N-1:0] busSrcSel;
  logic [NS-1:0]       busImmSel;
  logic [NS*DST_N-1:0] busDstWe;
  logic [NS-1:0]       busLive;
  logic [31:0]         immValue;
  logic                dstClash;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mvdec_top #(.SRC_SOCKETS(SRC_N)) dut (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrWord(instrWord),
    .guardFlags(guardFlags), .busSrcSel(busSrcSel), .busImmSel(busImmSel),
    .busDstWe(busDstWe), .busLive(busLive), .immValue(immValue), .dstClash(dstClash)
  );

  // slot, guard, src, dst, flags, expLive, expImm
  localparam logic [24:0] VEC [NVEC] = '{
    {4'd0, 2'd0, 9'd5,   6'd40, 2'b00, 1'b1, 1'b0},
    {4'd1, 2'd1, 9'd5,   6'd40, 2'b00, 1'b0, 1'b0},
    {4'd2, 2'd2, 9'd3,   6'd2,  2'b01, 1'b1, 1'b0},
    {4'd3, 2'd2, 9'd3,   6'd2,  2'b10, 1'b0, 1'b0},
    {4'd4, 2'd3, 9'd3,   6'd31, 2'b10, 1'b1, 1'b0},
    {4'd5, 2'd3, 9'd3,   6'd31, 2'b01, 1'b0, 1'b0},
    {4'd6, 2'd0, 9'd511, 6'd63, 2'b00, 1'b1, 1'b1},
    {4'd7, 2'd0, 9'd40,  6'd7,  2'b00, 1'b0, 1'b0},
    {4'd8, 2'd0, 9'd31,  6'd0,  2'b00, 1'b1, 1'b0},
    {4'd3, 2'd0, 9'd0,   6'd17, 2'b00, 1'b1, 1'b0},
    {4'd7, 2'd0, 9'd510, 6'd9,  2'b00, 1'b0, 1'b0},
    {4'd8, 2'd1, 9'd511, 6'd5,  2'b00, 1'b0, 1'b0},
    {4'd6, 2'd0, 9'd31,  6'd63, 2'b11, 1'b1, 1'b0},
    {4'd0, 2'd3, 9'd511, 6'd0,  2'b11, 1'b1, 1'b1}
  };

  function automatic int tbDstW(input int s);
    return (s < 3 || s == 6) ? 6 : 5;
  endfunction

  function automatic int tbBase(input int s);
    int b;
    b = 0;
    for (int k = 0; k < s; k++) b += 11 + tbDstW(k);
    return b;
  endfunction

  function automatic logic [WW-1:0] putSlot(input logic [WW-1:0] w, input int s,
      input logic [1:0] g, input logic [8:0] src, input logic [5:0] dst);
    logic [WW-1:0] r;
    int b;
    int dw;
    r = w;
    b = tbBase(s);
    dw = tbDstW(s);
    for (int i = 0; i < dw; i++) r[b+i] = dst[i];
    for (int i = 0; i < 9; i++)  r[b+dw+i] = src[i];
    for (int i = 0; i < 2; i++)  r[b+dw+9+i] = g[i];
    return r;
  endfunction

  function automatic logic [WW-1:0] nopWord(input logic [31:0] imm);
    logic [WW-1:0] r;
    r = '0;
    for (int s = 0; s < NS; s++) r = putSlot(r, s, 2'd1, 9'd0, 6'd0);
    r[179:148] = imm;
    return r;
  endfunction

  task automatic cmp(input string tag, input logic [575:0] act, input logic [575:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic [WW-1:0] w, input logic [1:0] f);
    @(negedge clk);
    instrValid = v;
    instrWord  = w;
    guardFlags = f;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [WW-1:0]       w;
    logic [NS*SRC_N-1:0] eSrc;
    logic [NS*DST_N-1:0] eDst;
    logic [NS-1:0]       eLive;
    logic [NS-1:0]       eImm;

    // R8: reset holds outputs at zero even with a live word presented
    w = '0;
    for (int s = 0; s < NS; s++) w = putSlot(w, s, 2'd0, 9'(s), 6'(s));
    instrValid = 1'b1;
    instrWord  = w;
    repeat (3) @(negedge clk);
    cmp("R8 live in reset", 576'(busLive), 576'(0));
    cmp("R8 dst enables in reset", 576'(busDstWe), 576'(0));
    cmp("R8 src selects in reset", 576'(busSrcSel), 576'(0));
    cmp("R8 imm in reset", 576'({immValue, busImmSel, dstClash}), 576'(0));
    instrValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;

    // table of single-slot words, others never-guarded
    for (int v = 0; v < NVEC; v++) begin
      int sl;
      logic [8:0] src;
      logic [5:0] dst;
      string tag;
      sl  = int'(VEC[v][24:21]);
      src = VEC[v][18:10];
      dst = VEC[v][9:4];
      w = putSlot(nopWord(32'h0), sl, VEC[v][20:19], src, dst);
      drive(1'b1, w, VEC[v][3:2]);
      eLive = '0; eImm = '0; eSrc = '0; eDst = '0;
      if (VEC[v][1]) begin
        eLive[sl] = 1'b1;
        eDst[sl*DST_N + int'(dst)] = 1'b1;
        if (VEC[v][0]) eImm[sl] = 1'b1;
        else eSrc[sl*SRC_N + int'(src)] = 1'b1;
      end
      tag = (VEC[v][20:19] != 2'd0) ? "R2" : "R3";
      cmp($sformatf("%s R1 vec%0d live", tag, v), 576'(busLive), 576'(eLive));
      cmp($sformatf("%s vec%0d src select", tag, v), 576'(busSrcSel), 576'(eSrc));
      cmp($sformatf("%s vec%0d imm select", tag, v), 576'(busImmSel), 576'(eImm));
      cmp($sformatf("R4 vec%0d dst enable", v), 576'(busDstWe), 576'(eDst));
      cmp($sformatf("R7 vec%0d no clash", v), 576'(dstClash), 576'(0));
    end

    // R9 and R6: all nine buses live at once with a constant field
    w = '0;
    for (int s = 0; s < NS; s++) w = putSlot(w, s, 2'd0, 9'(s), 6'(s + 10));
    w[179:148] = 32'hDEADBEEF;
    drive(1'b1, w, 2'b00);
    eSrc = '0; eDst = '0;
    for (int s = 0; s < NS; s++) begin
      eSrc[s*SRC_N + s] = 1'b1;
      eDst[s*DST_N + s + 10] = 1'b1;
    end
    cmp("R9 all buses live", 576'(busLive), 576'(9'h1FF));
    cmp("R9 all source selects", 576'(busSrcSel), 576'(eSrc));
    cmp("R9 all dst enables", 576'(busDstWe), 576'(eDst));
    cmp("R6 constant field", 576'(immValue), 576'(32'hDEADBEEF));
    cmp("R7 distinct destinations", 576'(dstClash), 576'(0));

    // R5: a bubble clears everything; the next word shows only after the edge
    drive(1'b0, w, 2'b00);
    cmp("R5 bubble live", 576'(busLive), 576'(0));
    cmp("R5 bubble dst", 576'(busDstWe), 576'(0));
    cmp("R5 bubble imm", 576'(immValue), 576'(0));
    @(negedge clk);
    instrValid = 1'b1;
    #1;
    cmp("R5 no change before edge", 576'(busLive), 576'(0));
    @(negedge clk);
    cmp("R5 change after edge", 576'(busLive), 576'(9'h1FF));

    // R7: two live slots name destination 12
    w = putSlot(nopWord(32'h0), 2, 2'd0, 9'd1, 6'd12);
    w = putSlot(w, 7, 2'd0, 9'd2, 6'd12);
    drive(1'b1, w, 2'b00);
    eDst = '0;
    eDst[2*DST_N + 12] = 1'b1;
    eDst[7*DST_N + 12] = 1'b1;
    cmp("R7 clash raised", 576'(dstClash), 576'(1));
    cmp("R7 both enables kept", 576'(busDstWe), 576'(eDst));

    // R7: partner guarded off by flag 1 low, no clash
    w = putSlot(nopWord(32'h0), 2, 2'd0, 9'd1, 6'd12);
    w = putSlot(w, 7, 2'd3, 9'd2, 6'd12);
    drive(1'b1, w, 2'b01);
    cmp("R7 squashed partner no clash", 576'(dstClash), 576'(0));
    cmp("R7 squashed partner live", 576'(busLive), 576'(9'b000000100));

    // R6 and R1: constant captured with no user; all-ones field does not leak into slot 8
    drive(1'b1, nopWord(32'hFFFFFFFF), 2'b11);
    cmp("R6 unused constant", 576'(immValue), 576'(32'hFFFFFFFF));
    cmp("R1 slot 8 boundary", 576'(busLive), 576'(0));
    drive(1'b1, nopWord(32'h12345678), 2'b00);
    cmp("R6 second constant", 576'(immValue), 576'(32'h12345678));

    finished = 1;
    summary();
    $finish;
  end

endmodule